// File: doc/BRIEF.md
# Shader output slot mapper

This block sits after a programmable vertex stage and turns that stage's output registers into a packed list of output slots. A 16-bit enable mask selects which output registers carry data. Only enabled registers receive a slot. They fill slots 0, 1, 2 and upward in ascending register order, with no gaps. A bank of slot registers gives each slot four 8-bit semantic codes, one for each component x, y, z and w. A total-slot count says how many slots downstream logic reads.

Within a vertex, which is framed by a start strobe and an end strobe, the shader issues writes. Each write carries a register index, a 4-bit component mask and four component values. The block records each component value and counts how often each enabled component is written. One cycle after the end strobe it presents every used slot's semantic codes and component values. At the same time it raises flags for four conditions: writes to disabled registers, components written twice, enabled components never written, and a slot count that does not agree with the mask.

Top module: `outslot_mapper`

## Requirements
- R1: A register whose enable bit is clear takes no slot. Enabled registers take slots 0, 1, 2 and upward in ascending register order with no gaps. For example, with mask 0x0011, register 0 maps to slot 0 and register 4 maps to slot 1.
- R2: For each slot s below the slot total:
  - `out_sem` bits [(4s+k)*8 +: 8] equal byte k (bits 8k+7:8k) of slot register s in `slot_map` (bits [32s +: 32]), where component k is 0=x, 1=y, 2=z, 3=w.
  - `out_data` bits [(4s+k)*16 +: 16] equal the recorded value of component k of the register mapped to slot s. That value comes from `wr_data` bits [16k +: 16].
- R3: Slots at or above the slot total are ignored: their `out_used` bit is 0 and their semantic and data fields read 0. A slot below the total with no register mapped to it has `out_used`=1, its semantics shown, and data 0.
- R4: A write to a register whose enable bit is clear is dropped and sets `err_stray` for that vertex.
- R5: A write to a component already written in the same vertex sets `err_double`. The first value written is kept.
- R6: At vertex end, if any component of an enabled register has no recorded write, `err_missing` is set.
- R7: `err_cfg` is set when the popcount of the mask differs from the slot total, or when the slot total exceeds the number of slots (8).
- R8: The start strobe clears all recorded values, write tracking and flags. A write in the same cycle as the start strobe counts toward the new vertex.
- R9: `out_valid` pulses for exactly the cycle after each end strobe. A write in the end-strobe cycle is included in that result. Result fields hold until the next end strobe.
- R10: After reset, `out_valid`, `out_used` and all four error flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_mask | input | 16 | Output register enable mask |
| slot_total | input | 5 | Number of slots in use |
| slot_map | input | 256 | Eight slot registers of four semantic bytes each |
| vtx_start | input | 1 | Vertex start strobe |
| vtx_end | input | 1 | Vertex end strobe |
| wr_valid | input | 1 | Shader output write strobe |
| wr_reg | input | 4 | Output register index of the write |
| wr_mask | input | 4 | Component write mask (bit k = component k) |
| wr_data | input | 64 | Four 16-bit component values |
| out_valid | output | 1 | Result strobe |
| out_used | output | 8 | Slot in-use bits |
| out_sem | output | 256 | Semantic code per slot component |
| out_data | output | 512 | Value per slot component |
| err_stray | output | 1 | Write to a disabled register seen |
| err_double | output | 1 | Component written more than once |
| err_missing | output | 1 | Enabled component never written |
| err_cfg | output | 1 | Mask and slot total disagree |

## Verification
The hardest case to reach is a write that lands in the same cycle as a strobe. A write in the start cycle must survive the clear. A write in the end cycle must still reach the result and the double-write flag. The stimulus drives such writes on purpose in directed vertices. The random vertices combine sparse masks with component masks that are split, dropped or repeated, so that every flag appears alone and together with the others.

// File: rtl/outslot_pkg.sv
package outslot_pkg;
  localparam int COMPS = 4;
  localparam int SEMW  = 8;

  function automatic int unsigned ones32(input logic [31:0] m);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(m[i]);
    return n;
  endfunction

  // slot index of register r: number of enabled registers below it
  function automatic int unsigned rank_of(input logic [31:0] m, input int unsigned r);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++)
      if (i < int'(r) && m[i]) n++;
    return n;
  endfunction
endpackage

// File: rtl/outslot_tracker.sv
module outslot_tracker
  import outslot_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DW       = 16,
  localparam int RW      = $clog2(NUM_REGS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_REGS-1:0]          en_mask,
  input  logic                         vtx_start,
  input  logic                         wr_valid,
  input  logic [RW-1:0]                wr_reg,
  input  logic [COMPS-1:0]             wr_mask,
  input  logic [COMPS*DW-1:0]          wr_data,
  output logic [NUM_REGS*COMPS*DW-1:0] data_nxt_flat,
  output logic                         stray_nxt,
  output logic                         dbl_nxt,
  output logic                         miss_nxt
);
  logic [NUM_REGS-1:0][COMPS-1:0]         written_q, written_nxt, base_w;
  logic [NUM_REGS-1:0][COMPS-1:0][DW-1:0] data_q, data_nxt;
  logic                                   stray_q, dbl_q;
  logic                                   wr_hit, evt_stray, evt_double;
  logic [COMPS-1:0]                       dup_bits, new_bits;

  always_comb begin
    evt_stray = wr_valid && !en_mask[wr_reg];
    wr_hit    = wr_valid && en_mask[wr_reg];
    base_w    = vtx_start ? '0 : written_q;
    dup_bits  = wr_hit ? (base_w[wr_reg] & wr_mask) : '0;
    new_bits  = wr_hit ? (wr_mask & ~base_w[wr_reg]) : '0;
    evt_double = |dup_bits;
    written_nxt = base_w;
    written_nxt[wr_reg] = base_w[wr_reg] | new_bits;
    data_nxt = vtx_start ? '0 : data_q;
    for (int k = 0; k < COMPS; k++)
      if (new_bits[k]) data_nxt[wr_reg][k] = wr_data[k*DW +: DW];
    stray_nxt = (vtx_start ? 1'b0 : stray_q) | evt_stray;
    dbl_nxt   = (vtx_start ? 1'b0 : dbl_q) | evt_double;
    miss_nxt  = 1'b0;
    for (int r = 0; r < NUM_REGS; r++)
      if (en_mask[r] && written_nxt[r] != {COMPS{1'b1}}) miss_nxt = 1'b1;
  end

  assign data_nxt_flat = data_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      written_q <= '0;
      data_q    <= '0;
      stray_q   <= 1'b0;
      dbl_q     <= 1'b0;
    end else begin
      written_q <= written_nxt;
      data_q    <= data_nxt;
      stray_q   <= stray_nxt;
      dbl_q     <= dbl_nxt;
    end
  end

  AST_STRAY_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stray |=> stray_q); // R4
  AST_DOUBLE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_double |=> dbl_q); // R5
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (vtx_start && !wr_valid) |=> (written_q == '0 && !stray_q && !dbl_q)); // R8
endmodule

// File: rtl/outslot_router.sv
module outslot_router
  import outslot_pkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int NUM_SLOTS = 8,
  parameter int DW        = 16,
  localparam int TW       = $clog2(NUM_REGS + 1)
) (
  input  logic [NUM_REGS-1:0]             en_mask,
  input  logic [TW-1:0]                   slot_total,
  input  logic [NUM_SLOTS*32-1:0]         slot_map,
  input  logic [NUM_REGS*COMPS*DW-1:0]    reg_data,
  output logic [NUM_SLOTS-1:0]            slot_used,
  output logic [NUM_SLOTS*COMPS*SEMW-1:0] slot_sem,
  output logic [NUM_SLOTS*COMPS*DW-1:0]   slot_data,
  output logic                            cfg_err
);
  logic [31:0] mask32;
  assign mask32 = 32'(en_mask);

  always_comb begin
    slot_used = '0;
    slot_sem  = '0;
    slot_data = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (s < int'(slot_total)) begin
        slot_used[s] = 1'b1;
        slot_sem[s*COMPS*SEMW +: COMPS*SEMW] = slot_map[s*32 +: 32];
        for (int r = 0; r < NUM_REGS; r++)
          if (en_mask[r] && rank_of(mask32, r) == s)
            slot_data[s*COMPS*DW +: COMPS*DW] = reg_data[r*COMPS*DW +: COMPS*DW];
      end
    end
    cfg_err = (ones32(mask32) != int'(slot_total)) || (int'(slot_total) > NUM_SLOTS);
  end
endmodule

// File: rtl/outslot_mapper.sv
module outslot_mapper
  import outslot_pkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int NUM_SLOTS = 8,
  parameter int DW        = 16,
  localparam int RW       = $clog2(NUM_REGS),
  localparam int TW       = $clog2(NUM_REGS + 1)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_REGS-1:0]             en_mask,
  input  logic [TW-1:0]                   slot_total,
  input  logic [NUM_SLOTS*32-1:0]         slot_map,
  input  logic                            vtx_start,
  input  logic                            vtx_end,
  input  logic                            wr_valid,
  input  logic [RW-1:0]                   wr_reg,
  input  logic [COMPS-1:0]                wr_mask,
  input  logic [COMPS*DW-1:0]             wr_data,
  output logic                            out_valid,
  output logic [NUM_SLOTS-1:0]            out_used,
  output logic [NUM_SLOTS*COMPS*SEMW-1:0] out_sem,
  output logic [NUM_SLOTS*COMPS*DW-1:0]   out_data,
  output logic                            err_stray,
  output logic                            err_double,
  output logic                            err_missing,
  output logic                            err_cfg
);
  logic [NUM_REGS*COMPS*DW-1:0]    reg_data;
  logic                            stray_nxt, dbl_nxt, miss_nxt, cfg_now;
  logic [NUM_SLOTS-1:0]            used_now;
  logic [NUM_SLOTS*COMPS*SEMW-1:0] sem_now;
  logic [NUM_SLOTS*COMPS*DW-1:0]   data_now;

  outslot_tracker #(.NUM_REGS(NUM_REGS), .DW(DW)) u_track (
    .clk(clk), .rst_n(rst_n), .en_mask(en_mask), .vtx_start(vtx_start),
    .wr_valid(wr_valid), .wr_reg(wr_reg), .wr_mask(wr_mask), .wr_data(wr_data),
    .data_nxt_flat(reg_data), .stray_nxt(stray_nxt), .dbl_nxt(dbl_nxt),
    .miss_nxt(miss_nxt)
  );

  outslot_router #(.NUM_REGS(NUM_REGS), .NUM_SLOTS(NUM_SLOTS), .DW(DW)) u_route (
    .en_mask(en_mask), .slot_total(slot_total), .slot_map(slot_map),
    .reg_data(reg_data), .slot_used(used_now), .slot_sem(sem_now),
    .slot_data(data_now), .cfg_err(cfg_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_used    <= '0;
      out_sem     <= '0;
      out_data    <= '0;
      err_stray   <= 1'b0;
      err_double  <= 1'b0;
      err_missing <= 1'b0;
      err_cfg     <= 1'b0;
    end else begin
      out_valid <= vtx_end;
      if (vtx_end) begin
        out_used    <= used_now;
        out_sem     <= sem_now;
        out_data    <= data_now;
        err_stray   <= stray_nxt;
        err_double  <= dbl_nxt;
        err_missing <= miss_nxt;
        err_cfg     <= cfg_now;
      end
    end
  end

  AST_VALID_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    vtx_end |=> out_valid); // R9
  AST_NO_VALID_WITHOUT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !vtx_end |=> !out_valid); // R9
  AST_USED_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_used & (out_used + 1'b1)) == '0)); // R1
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !vtx_end |=> $stable(out_data) && $stable(out_used)); // R9
endmodule

// File: tb/outslot_mapper_test.sv
module outslot_mapper_test;
  localparam int NR = 16, NS = 8, DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NR-1:0] en_mask = '0;
  logic [4:0] slot_total = '0;
  logic [NS*32-1:0] slot_map = '0;
  logic vtx_start = 0, vtx_end = 0, wr_valid = 0;
  logic [3:0] wr_reg = '0, wr_mask = '0;
  logic [63:0] wr_data = '0;
  logic out_valid, err_stray, err_double, err_missing, err_cfg;
  logic [NS-1:0] out_used;
  logic [NS*32-1:0] out_sem;
  logic [NS*64-1:0] out_data;

  int checks = 0, errors = 0;
  bit mw[NR][4];
  logic [15:0] md[NR][4];
  bit m_stray, m_dbl;

  always #10ns clk = ~clk;

  outslot_mapper uut (
    .clk(clk), .rst_n(rst_n), .en_mask(en_mask), .slot_total(slot_total),
    .slot_map(slot_map), .vtx_start(vtx_start), .vtx_end(vtx_end),
    .wr_valid(wr_valid), .wr_reg(wr_reg), .wr_mask(wr_mask), .wr_data(wr_data),
    .out_valid(out_valid), .out_used(out_used), .out_sem(out_sem),
    .out_data(out_data), .err_stray(err_stray), .err_double(err_double),
    .err_missing(err_missing), .err_cfg(err_cfg)
  );

  task automatic chk(string tag, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int r = 0; r < NR; r++)
      for (int k = 0; k < 4; k++) begin mw[r][k] = 0; md[r][k] = '0; end
    m_stray = 0; m_dbl = 0;
  endtask

  task automatic model_write(int r, logic [3:0] m, logic [63:0] d);
    if (!en_mask[r]) m_stray = 1;
    else
      for (int k = 0; k < 4; k++)
        if (m[k]) begin
          if (mw[r][k]) m_dbl = 1;
          else begin mw[r][k] = 1; md[r][k] = d[16*k +: 16]; end
        end
  endtask

  task automatic check_result();
    logic [511:0] ed, es;
    logic [7:0] eu;
    int slot, pc;
    bit miss, cfg;
    ed = '0; es = '0; eu = '0; slot = 0; pc = 0; miss = 0;
    for (int s = 0; s < NS; s++)
      if (s < int'(slot_total)) begin
        eu[s] = 1'b1;
        es[32*s +: 32] = slot_map[32*s +: 32];
      end
    for (int r = 0; r < NR; r++)
      if (en_mask[r]) begin
        pc++;
        for (int k = 0; k < 4; k++) if (!mw[r][k]) miss = 1;
        if (slot < int'(slot_total) && slot < NS)
          for (int k = 0; k < 4; k++) ed[(slot*4+k)*16 +: 16] = md[r][k];
        slot++;
      end
    cfg = (pc != int'(slot_total)) || (int'(slot_total) > NS);
    chk("R9 out_valid after end", 512'(out_valid), 512'(1));
    chk("R1 R3 out_used", 512'(out_used), 512'(eu));
    chk("R2 R3 out_sem", 512'(out_sem), es);
    chk("R1 R2 out_data", out_data, ed);
    chk("R4 err_stray", 512'(err_stray), 512'(m_stray));
    chk("R5 err_double", 512'(err_double), 512'(m_dbl));
    chk("R6 err_missing", 512'(err_missing), 512'(miss));
    chk("R7 err_cfg", 512'(err_cfg), 512'(cfg));
  endtask

  task automatic cyc(bit st, bit en, bit wv, int r, logic [3:0] m, logic [63:0] d);
    vtx_start = st; vtx_end = en; wr_valid = wv;
    wr_reg = 4'(r); wr_mask = m; wr_data = d;
    if (st) model_clear();
    if (wv) model_write(r, m, d);
    @(negedge clk);
    vtx_start = 0; vtx_end = 0; wr_valid = 0;
    if (en) check_result();
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  task automatic random_vertex();
    logic [15:0] mk;
    int pc;
    logic [3:0] full, m1, m2;
    mk = 16'($urandom & $urandom);
    pc = 0;
    for (int i = 0; i < NR; i++) pc += int'(mk[i]);
    en_mask = mk;
    slot_total = 5'(pc);
    if ($urandom % 6 == 0) slot_total = 5'($urandom % 17);
    for (int s = 0; s < NS; s++) slot_map[32*s +: 32] = $urandom;
    cyc(1, 0, 0, 0, 4'h0, '0);
    for (int r = 0; r < NR; r++)
      if (mk[r]) begin
        int mode;
        mode = int'($urandom % 8);
        full = 4'hF;
        if (mode == 0) full[$urandom % 4] = 1'b0;
        m1 = 4'($urandom) & full;
        m2 = full & ~m1;
        if (m1 != 0) cyc(0, 0, 1, r, m1, rnd64());
        if (m2 != 0) cyc(0, 0, 1, r, m2, rnd64());
        if (mode == 1) cyc(0, 0, 1, r, 4'(1 << ($urandom % 4)), rnd64());
      end
    if ($urandom % 5 == 0) begin
      int r;
      r = int'($urandom % 16);
      if (!mk[r]) cyc(0, 0, 1, r, 4'hF, rnd64());
    end
    cyc(0, 1, 0, 0, 4'h0, '0);
  endtask

  initial begin
    #3ms;
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    model_clear();
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset out_valid", 512'(out_valid), 512'(0));
    chk("R10 reset out_used", 512'(out_used), 512'(0));
    chk("R10 reset flags", 512'({err_stray, err_double, err_missing, err_cfg}), 512'(0));
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 directed: mask 0x0011, two slots
    en_mask = 16'h0011; slot_total = 5'd2;
    slot_map = '0;
    slot_map[31:0] = 32'h03020100; slot_map[63:32] = 32'h0B0A0908;
    cyc(1, 0, 0, 0, 4'h0, '0);
    cyc(0, 0, 1, 4, 4'hF, 64'h4444_3333_2222_1111);
    cyc(0, 0, 1, 0, 4'hF, 64'hDDDD_CCCC_BBBB_AAAA);
    cyc(0, 1, 0, 0, 4'h0, '0);
    @(negedge clk);
    chk("R9 out_valid single pulse", 512'(out_valid), 512'(0));
    chk("R9 result held", out_data[127:0], {64'h4444_3333_2222_1111, 64'hDDDD_CCCC_BBBB_AAAA});

    // R8 write in start cycle, R9 write in end cycle, R5 double in end cycle
    en_mask = 16'h0102; slot_total = 5'd2;
    cyc(1, 0, 1, 1, 4'hF, 64'h0004_0003_0002_0001);
    cyc(0, 0, 1, 8, 4'h3, 64'h0000_0000_0006_0005);
    cyc(0, 1, 1, 8, 4'hE, 64'h0009_0008_0007_0066);

    // R3 total below popcount, R4 stray, R6 missing
    en_mask = 16'h0007; slot_total = 5'd1;
    cyc(1, 0, 0, 0, 4'h0, '0);
    cyc(0, 0, 1, 0, 4'hF, 64'h1234_5678_9ABC_DEF0);
    cyc(0, 0, 1, 9, 4'hF, 64'hFFFF_FFFF_FFFF_FFFF);
    cyc(0, 0, 1, 1, 4'h7, 64'h0000_0003_0002_0001);
    cyc(0, 1, 0, 0, 4'h0, '0);

    // R3 total above popcount, R7 total beyond slot count
    en_mask = 16'h8000; slot_total = 5'd3;
    cyc(1, 0, 0, 0, 4'h0, '0);
    cyc(0, 0, 1, 15, 4'hF, 64'h0F0F_0E0E_0D0D_0C0C);
    cyc(0, 1, 0, 0, 4'h0, '0);
    en_mask = 16'h01FF; slot_total = 5'd9;
    cyc(1, 0, 0, 0, 4'h0, '0);
    for (int r = 0; r < 9; r++) cyc(0, 0, 1, r, 4'hF, rnd64());
    cyc(0, 1, 0, 0, 4'h0, '0);

    // R8 flags cleared by next start
    en_mask = 16'h0001; slot_total = 5'd1;
    cyc(1, 0, 0, 0, 4'h0, '0);
    cyc(0, 0, 1, 0, 4'hF, rnd64());
    cyc(0, 1, 0, 0, 4'h0, '0);

    for (int v = 0; v < 300; v++) random_vertex();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule